// File: doc/BRIEF.md
# Dual-Clock Nine-Bit FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words with a write side and a read side that each run on their own free-running clock. The two clocks may be the same net or entirely unrelated. Each side is qualified by two enable inputs. Either enable can serve as the system enable while the other is left to external expansion logic. The read side ends in an output register, and a separate active-low output-enable pin drives the companion drive-enable output. A surrounding pad or bus stage uses that pair to build a three-state output.

Pointers cross between the clock domains as Gray codes through two-stage synchronizers. Empty and almost-empty are produced in the read domain. Full and almost-full are produced in the write domain. The two almost thresholds sit in offset registers. These are loaded through the second write enable, which doubles as a load strobe: while it is low and the first write enable is low, the write word goes to the offsets and not to the memory.

Flow control is by flags rather than a ready handshake. The full flag is the write side's back-pressure: a write attempted while it is high is dropped. The empty flag is the read side's valid indication: a read attempted while it is high is dropped and the output register holds. Both flags are conservative, so neither side can overrun or underrun the other.

Top module: `dcfifo9`

## Requirements
- R1: A word is stored at a rising `wclk` edge only when `wen1_n` is 0, `wen2_ld` is 1 and `full` is 0. If `wen1_n` is 1, nothing is stored, whatever the value of `wen2_ld`.
- R2: At a rising `rclk` edge where `ren1_n` and `ren2_n` are both 0 and `empty` is 0, the oldest stored word is loaded into `q_data`. Words leave in write order. If either read enable is 1, `q_data` holds.
- R3: Writes attempted while `full` is 1 are dropped, so the FIFO never holds more than DEPTH words.
- R4: Reads attempted while `empty` is 1 leave the read pointer and `q_data` unchanged.
- R5: `empty` is a read-domain register computed from the write pointer after two read-clock synchronizer stages. With one shared clock, a write on edge n clears `empty` at edge n+3. A read on edge n that takes the last visible word sets `empty` at edge n.
- R6: `full` is a write-domain register computed from the read pointer after two write-clock synchronizer stages. With one shared clock, a write on edge n that brings the count to DEPTH sets `full` at edge n. A read on edge n clears it at edge n+3.
- R7: `almost_empty` is 1 when the fill count seen in the read domain is less than or equal to the almost-empty offset. It has the same timing as `empty`.
- R8: `almost_full` is 1 when DEPTH minus the count seen in the write domain is less than or equal to the almost-full offset. It has the same timing as `full`.
- R9: When `wen1_n` is 0 and `wen2_ld` is 0 at a `wclk` edge, `din` is loaded into an offset register and not into the memory. Successive loads go to the almost-empty offset first, then the almost-full offset, and then alternate.
- R10: `q_oe` is the inverse of `oe_n` at all times, and `oe_n` has no effect on `q_data`.
- R11: While `rst_n` is 0, `empty` and `almost_empty` are 1, `full` and `almost_full` are 0, `q_data` is 0 and both pointers are 0. Reset also returns both offsets to 7 and makes the next load go to the almost-empty offset.
- R12: With unrelated clocks, every accepted word is read back in order, and each Gray pointer changes by at most one bit per edge of its own clock. Once both sides go idle, the flags settle to the values that R5 to R8 give for the true count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wen1_n | input | 1 | Write enable, active low |
| wen2_ld | input | 1 | Write enable when high; offset load strobe when low |
| din | input | 9 | Write data, or offset value during a load |
| ren1_n | input | 1 | Read enable, active low |
| ren2_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output drive enable, active low |
| q_data | output | 9 | Registered read data |
| q_oe | output | 1 | Drive enable for the output stage |
| empty | output | 1 | No word visible to the read side |
| full | output | 1 | No free space visible to the write side |
| almost_empty | output | 1 | Fill count at or below the almost-empty offset |
| almost_full | output | 1 | Free space at or below the almost-full offset |

## Verification
Some properties are checked on every cycle by the assertions:
- a blocked write on full leaves the write pointer still;
- a blocked read on empty leaves the read pointer and output still;
- an offset load never moves the write pointer;
- Gray pointers step by one bit;
- each full or empty flag implies its almost partner;
- the reset values hold.

Other behaviour can only be shown by the bench's scenarios:
- the exact three-edge flag latency with tied clocks;
- the threshold crossings after offsets are loaded in their alternating order;
- the default offsets after a second reset;
- the ordered delivery and settled flags under a 5 ns / 7 ns clock pair.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int unsigned WORD_W      = 9;
  localparam int unsigned SYNC_STAGES = 2;

  typedef logic [WORD_W-1:0] word_t;

  // Which offset register the next load strobe targets.
  typedef enum logic {
    LD_AE = 1'b0,
    LD_AF = 1'b1
  } ld_sel_e;

  localparam word_t OFS_RESET = word_t'(7);
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram
  import dcf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  localparam int unsigned WORDS = 1 << AW;

  word_t mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  word_t         din,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          full,
  output logic          almost_full,
  output word_t         ae_ofs
);
  localparam int PW = AW + 1;
  localparam int CW = (PW > int'(WORD_W)) ? PW : int'(WORD_W);
  localparam logic [CW-1:0] DEPTH_C = CW'(1) << AW;
  localparam logic [AW:0]   FULL_CNT = {1'b1, {AW{1'b0}}};

  logic [AW:0]   wbin, wbin_nxt, rbin_s, used_nxt;
  logic [CW-1:0] free_nxt;
  logic          wr_req, ld_req;
  word_t         af_ofs;
  ld_sel_e       ld_sel;

  // Gray to binary for the synchronized read pointer.
  always_comb begin
    rbin_s[AW] = rgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
  end

  assign wr_req   = !wen1_n && wen2_ld;
  assign ld_req   = !wen1_n && !wen2_ld;
  assign we       = wr_req && !full;
  assign wbin_nxt = wbin + {{AW{1'b0}}, we};
  assign used_nxt = wbin_nxt - rbin_s;
  assign free_nxt = DEPTH_C - CW'(used_nxt);
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin        <= '0;
      wgray       <= '0;
      full        <= 1'b0;
      almost_full <= 1'b0;
    end else begin
      wbin        <= wbin_nxt;
      wgray       <= wbin_nxt ^ (wbin_nxt >> 1);
      full        <= (used_nxt == FULL_CNT);
      almost_full <= (free_nxt <= CW'(af_ofs));
    end
  end

  // Offset registers share the write port; loads alternate between them.
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      ae_ofs <= OFS_RESET;
      af_ofs <= OFS_RESET;
      ld_sel <= LD_AE;
    end else if (ld_req) begin
      unique case (ld_sel)
        LD_AE: begin
          ae_ofs <= din;
          ld_sel <= LD_AF;
        end
        LD_AF: begin
          af_ofs <= din;
          ld_sel <= LD_AE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic [AW:0]   wgray_s,
  input  word_t         rdata,
  input  word_t         ae_ofs,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          empty,
  output logic          almost_empty,
  output word_t         q_data
);
  localparam int PW = AW + 1;
  localparam int CW = (PW > int'(WORD_W)) ? PW : int'(WORD_W);

  logic [AW:0] rbin, rbin_nxt, wbin_s, fill_nxt;
  logic        re;

  always_comb begin
    wbin_s[AW] = wgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
  end

  assign re       = !ren1_n && !ren2_n && !empty;
  assign rbin_nxt = rbin + {{AW{1'b0}}, re};
  assign fill_nxt = wbin_s - rbin_nxt;
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin         <= '0;
      rgray        <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b1;
      q_data       <= '0;
    end else begin
      rbin         <= rbin_nxt;
      rgray        <= rbin_nxt ^ (rbin_nxt >> 1);
      empty        <= (fill_nxt == '0);
      almost_empty <= (CW'(fill_nxt) <= CW'(ae_ofs));
      if (re) q_data <= rdata;
    end
  end
endmodule

// File: rtl/dcfifo9.sv
module dcfifo9
  import dcf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       wclk,
  input  logic       rclk,
  input  logic       rst_n,
  input  logic       wen1_n,
  input  logic       wen2_ld,
  input  logic [8:0] din,
  input  logic       ren1_n,
  input  logic       ren2_n,
  input  logic       oe_n,
  output logic [8:0] q_data,
  output logic       q_oe,
  output logic       empty,
  output logic       full,
  output logic       almost_empty,
  output logic       almost_full
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          we;
  word_t         rdata, ae_ofs;

  dcf_wr_side #(.AW(AW)) u_wr (
    .wclk        (wclk),
    .rst_n       (rst_n),
    .wen1_n      (wen1_n),
    .wen2_ld     (wen2_ld),
    .din         (din),
    .rgray_s     (rgray_s),
    .wgray       (wgray),
    .we          (we),
    .waddr       (waddr),
    .full        (full),
    .almost_full (almost_full),
    .ae_ofs      (ae_ofs)
  );

  dcf_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk   (wclk),
    .rst_n (rst_n),
    .d     (rgray),
    .q     (rgray_s)
  );

  dcf_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk   (rclk),
    .rst_n (rst_n),
    .d     (wgray),
    .q     (wgray_s)
  );

  dcf_ram #(.AW(AW)) u_ram (
    .wclk  (wclk),
    .we    (we),
    .waddr (waddr),
    .wdata (din),
    .raddr (raddr),
    .rdata (rdata)
  );

  dcf_rd_side #(.AW(AW)) u_rd (
    .rclk         (rclk),
    .rst_n        (rst_n),
    .ren1_n       (ren1_n),
    .ren2_n       (ren2_n),
    .wgray_s      (wgray_s),
    .rdata        (rdata),
    .ae_ofs       (ae_ofs),
    .rgray        (rgray),
    .raddr        (raddr),
    .empty        (empty),
    .almost_empty (almost_empty),
    .q_data       (q_data)
  );

  assign q_oe = ~oe_n;
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int AW = 6
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst_n,
  input logic        wen1_n,
  input logic        wen2_ld,
  input logic        ren1_n,
  input logic        ren2_n,
  input logic        full,
  input logic        empty,
  input logic        almost_full,
  input logic        almost_empty,
  input logic [AW:0] wgray,
  input logic [AW:0] rgray,
  input logic [8:0]  q_data
);
  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    (full && !wen1_n && wen2_ld) |=> $stable(wgray));

  assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    (empty && !ren1_n && !ren2_n) |=> ($stable(rgray) && $stable(q_data)));

  assert_load_skips_mem_R9: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wen1_n && !wen2_ld) |=> $stable(wgray));

  assert_full_has_af_R8: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> almost_full);

  assert_empty_has_ae_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> almost_empty);

  assert_wgray_step_R12: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_step_R12: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  assert_reset_rd_R11: assert property (@(posedge rclk)
    !rst_n |-> (empty && almost_empty && q_data == 9'd0 && rgray == '0));

  assert_reset_wr_R11: assert property (@(posedge wclk)
    !rst_n |-> (!full && !almost_full && wgray == '0));
endmodule

bind dcfifo9 dcf_chk #(.AW(AW)) u_chk (
  .wclk         (wclk),
  .rclk         (rclk),
  .rst_n        (rst_n),
  .wen1_n       (wen1_n),
  .wen2_ld      (wen2_ld),
  .ren1_n       (ren1_n),
  .ren2_n       (ren2_n),
  .full         (full),
  .empty        (empty),
  .almost_full  (almost_full),
  .almost_empty (almost_empty),
  .wgray        (wgray),
  .rgray        (rgray),
  .q_data       (q_data)
);

// File: tb/sim_dcfifo9.sv
`timescale 1ns/100ps
module sim_dcfifo9;
  localparam int DEPTH = 64;

  logic wclk = 1'b0, rclk = 1'b0, tie = 1'b1, rst_n = 1'b1;
  logic wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] q_data;
  logic q_oe, empty, full, almost_empty, almost_full;

  dcfifo9 #(.DEPTH(DEPTH)) u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .q_data(q_data),
    .q_oe(q_oe), .empty(empty), .full(full), .almost_empty(almost_empty),
    .almost_full(almost_full)
  );

  int n_cmp = 0, n_bad = 0, ticks = 0;
  bit done = 0;

  // 200 MHz write clock; read clock follows it when tied, else 7 ns period.
  initial forever begin
    #0.5;
    ticks++;
    if (ticks % 5 == 0) wclk = ~wclk;
    if (tie) rclk = wclk;
    else if (ticks % 7 == 0) rclk = ~rclk;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [8:0] mq[$];
  logic [8:0] qm;
  int wc, rc, ae_o, af_o;
  int wh[3];
  int rh[3];
  bit sel, pe, pf, pae, paf, rd_pend;
  bit wf, lf, rf, wf_a, lf_a, rf_a;
  int aeo_pre, afo_pre;

  task automatic model_reset();
    mq.delete();
    qm = '0; wc = 0; rc = 0; ae_o = 7; af_o = 7; sel = 0;
    for (int i = 0; i < 3; i++) begin wh[i] = 0; rh[i] = 0; end
    pe = 1; pf = 0; pae = 1; paf = 0; rd_pend = 0;
  endtask

  // Shared-clock model: exact per-edge flag prediction.
  always @(posedge wclk) if (tie && rst_n) begin
    wf = !wen1_n && wen2_ld && !pf;
    lf = !wen1_n && !wen2_ld;
    rf = !ren1_n && !ren2_n && !pe;
    aeo_pre = ae_o; afo_pre = af_o;
    if (wf) begin mq.push_back(din); wc++; end
    if (lf) begin
      if (!sel) ae_o = int'(din); else af_o = int'(din);
      sel = !sel;
    end
    if (rf && mq.size() > 0) begin qm = mq.pop_front(); rc++; end
    pe  = (wh[2] == rc);
    pf  = ((wc - rh[2]) == DEPTH);
    pae = ((wh[2] - rc) <= aeo_pre);
    paf = ((DEPTH - (wc - rh[2])) <= afo_pre);
    wh[2] = wh[1]; wh[1] = wh[0]; wh[0] = wc;
    rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = rc;
  end

  always @(negedge wclk) if (tie && rst_n) begin
    chk("R5", "empty", int'(empty), int'(pe));
    chk("R6", "full", int'(full), int'(pf));
    chk("R7", "almost_empty", int'(almost_empty), int'(pae));
    chk("R8", "almost_full", int'(almost_full), int'(paf));
    chk("R2", "q_data", int'(q_data), int'(qm));
  end

  // Unrelated-clock model: acceptance follows the observed flags.
  always @(posedge wclk) if (!tie && rst_n) begin
    wf_a = !wen1_n && wen2_ld && !full;
    lf_a = !wen1_n && !wen2_ld;
    if (lf_a) begin
      if (!sel) ae_o = int'(din); else af_o = int'(din);
      sel = !sel;
    end
    if (wf_a) begin
      if (mq.size() >= DEPTH) chk("R3", "accepted write beyond depth", mq.size(), DEPTH - 1);
      mq.push_back(din); wc++;
    end
  end

  always @(posedge rclk) if (!tie && rst_n) begin
    rf_a = !ren1_n && !ren2_n && !empty;
    if (rf_a) begin
      if (mq.size() == 0) chk("R4", "read accepted with no word", 0, 1);
      else begin qm = mq.pop_front(); rd_pend = 1; end
      rc++;
    end
  end

  always @(negedge rclk) if (!tie && rst_n && rd_pend) begin
    chk("R12", "q_data order", int'(q_data), int'(qm));
    rd_pend = 0;
  end

  task automatic cyc(input logic w1, input logic w2, input logic [8:0] d,
                     input logic r1, input logic r2);
    @(negedge wclk);
    wen1_n = w1; wen2_ld = w2; din = d; ren1_n = r1; ren2_n = r2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 9'd0, 1, 1);
  endtask

  task automatic do_reset(input bit tied);
    @(negedge wclk);
    wen1_n = 1; wen2_ld = 1; ren1_n = 1; ren2_n = 1;
    rst_n = 0;
    tie = tied;
    model_reset();
    repeat (4) @(negedge wclk);
    rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    #1 rst_n = 0;
    repeat (4) @(negedge wclk);
    rst_n = 1;
    idle(2);
    // R11 reset state
    chk("R11", "empty", int'(empty), 1);
    chk("R11", "almost_empty", int'(almost_empty), 1);
    chk("R11", "full", int'(full), 0);
    chk("R11", "almost_full", int'(almost_full), 0);
    chk("R11", "q_data", int'(q_data), 0);
    // R10 output enable
    oe_n = 0; #1;
    chk("R10", "q_oe low oe_n", int'(q_oe), 1);
    oe_n = 1; #1;
    chk("R10", "q_oe high oe_n", int'(q_oe), 0);
    chk("R10", "q_data unaffected", int'(q_data), 0);
    // R1 first enable inactive: no store
    cyc(1, 1, 9'h1AA, 1, 1); cyc(1, 1, 9'h1AA, 1, 1);
    cyc(1, 0, 9'h1AA, 1, 1); cyc(1, 0, 9'h1AA, 1, 1);
    idle(5);
    chk("R1", "empty after disabled writes", int'(empty), 1);
    // three writes, then reads with one enable high
    cyc(0, 1, 9'h101, 1, 1); cyc(0, 1, 9'h102, 1, 1); cyc(0, 1, 9'h103, 1, 1);
    idle(5);
    cyc(1, 1, 0, 0, 1); cyc(1, 1, 0, 0, 1); cyc(1, 1, 0, 1, 0); cyc(1, 1, 0, 1, 0);
    idle(2);
    chk("R2", "q_data held with one read enable high", int'(q_data), 0);
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0);
    idle(4);
    chk("R2", "last of three", int'(q_data), 'h103);
    chk("R5", "empty after drain", int'(empty), 1);
    // overfill
    for (int i = 0; i < 70; i++) cyc(0, 1, 9'(i), 1, 1);
    idle(5);
    chk("R3", "full after overfill", int'(full), 1);
    chk("R8", "almost_full when full", int'(almost_full), 1);
    for (int i = 0; i < 70; i++) cyc(1, 1, 0, 0, 0);
    idle(5);
    chk("R3", "last word kept is 63", int'(q_data), 63);
    chk("R4", "q_data held after reads on empty", int'(q_data), 63);
    chk("R4", "empty", int'(empty), 1);
    // simultaneous traffic
    for (int i = 0; i < 40; i++) cyc(0, 1, 9'(256 + i), (i % 2 == 0), (i % 2 == 0));
    for (int i = 0; i < 40; i++) cyc(1, 1, 0, 0, 0);
    idle(5);
    chk("R2", "last of mixed traffic", int'(q_data), 256 + 39);
    // offset loads: ae=5, af=10, ae=20
    for (int i = 0; i < 4; i++) cyc(0, 1, 9'(8'h50 + i), 1, 1);
    cyc(0, 0, 9'd5, 1, 1); cyc(0, 0, 9'd10, 1, 1); cyc(0, 0, 9'd20, 1, 1);
    for (int i = 4; i < 8; i++) cyc(0, 1, 9'(8'h50 + i), 1, 1);
    idle(5);
    chk("R9", "almost_empty at fill 8 with offset 20", int'(almost_empty), 1);
    for (int i = 0; i < 8; i++) cyc(1, 1, 0, 0, 0);
    idle(4);
    chk("R9", "load words not stored", int'(q_data), 'h57);
    for (int i = 0; i < 15; i++) cyc(0, 1, 9'(i), 1, 1);
    idle(5);
    chk("R9", "almost_empty at fill 15", int'(almost_empty), 1);
    for (int i = 0; i < 6; i++) cyc(0, 1, 9'(i), 1, 1);
    idle(5);
    chk("R9", "almost_empty at fill 21", int'(almost_empty), 0);
    for (int i = 0; i < 32; i++) cyc(0, 1, 9'(i), 1, 1);
    idle(5);
    chk("R9", "almost_full at free 11 offset 10", int'(almost_full), 0);
    cyc(0, 1, 9'd7, 1, 1);
    idle(5);
    chk("R9", "almost_full at free 10 offset 10", int'(almost_full), 1);
    for (int i = 0; i < 60; i++) cyc(1, 1, 0, 0, 0);
    idle(5);
    // second reset restores default offsets
    do_reset(1);
    idle(2);
    chk("R11", "full after second reset", int'(full), 0);
    chk("R11", "empty after second reset", int'(empty), 1);
    for (int i = 0; i < 7; i++) cyc(0, 1, 9'(i), 1, 1);
    idle(5);
    chk("R11", "almost_empty at fill 7 default offset", int'(almost_empty), 1);
    cyc(0, 1, 9'd7, 1, 1);
    idle(5);
    chk("R11", "almost_empty at fill 8 default offset", int'(almost_empty), 0);
    for (int i = 0; i < 10; i++) cyc(1, 1, 0, 0, 0);
    idle(5);

    // unrelated clocks
    do_reset(0);
    fork
      begin
        int k = 0;
        while (wc < 300) begin
          @(negedge wclk);
          if (wc >= 300) break;
          wen1_n = (k % 5 == 3); wen2_ld = 1; din = 9'(wc * 7 + 3);
          k++;
        end
        wen1_n = 1;
      end
      begin
        int k = 0;
        while (rc < 300) begin
          @(negedge rclk);
          if (rc >= 300) break;
          ren1_n = (k % 4 == 1); ren2_n = 0;
          k++;
        end
        ren1_n = 1; ren2_n = 1;
      end
    join
    repeat (12) @(negedge wclk);
    chk("R12", "empty settled", int'(empty), 1);
    chk("R12", "almost_empty settled", int'(almost_empty), 1);
    chk("R12", "full settled", int'(full), 0);
    chk("R12", "almost_full settled", int'(almost_full), 0);
    chk("R12", "words read", rc, 300);
    for (int i = 0; i < 80; i++) begin
      @(negedge wclk);
      wen1_n = 0; wen2_ld = 1; din = 9'(wc * 7 + 3);
    end
    @(negedge wclk);
    wen1_n = 1;
    repeat (12) @(negedge wclk);
    chk("R3", "accepted count capped at depth", wc - rc, DEPTH);
    chk("R12", "full settled", int'(full), 1);
    chk("R12", "almost_full settled", int'(almost_full), 1);
    chk("R12", "empty settled", int'(empty), 0);
    chk("R12", "almost_empty settled", int'(almost_empty), 0);
    for (int i = 0; i < 80; i++) begin
      @(negedge rclk);
      ren1_n = 0; ren2_n = 0;
    end
    @(negedge rclk);
    ren1_n = 1; ren2_n = 1;
    repeat (12) @(negedge wclk);
    chk("R12", "empty after drain", int'(empty), 1);
    chk("R12", "all words read", rc, wc);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule